// File: doc/BRIEF.md
# Network Controller Suspend Sequencer

This block decides how a network controller enters and leaves suspend. Software writes a control word. One bit of the word asks for suspend, and another bit chooses between two entry methods. The choice is taken from the same write that sets the request. After the request is taken, the block drives inhibit lines toward the DMA engines and the MAC. Once the controller has quiesced, it raises a suspended flag.

In the fast method the block lets in-flight work finish: DMA transfers already started and frames already on the wire in either direction. It blocks everything new, and it may report suspended while frames are still held in the FIFOs or the external buffer. In the draining method the block also waits until both directions have emptied their FIFO and external buffer. Stored transmit frames go out on the wire and stored receive frames go to system memory. During the drain it raises a flush request and keeps open only the paths that are needed to empty the buffers.

Writing the request bit back to zero leaves suspend. A soft reset or a stop command abandons any sequence at once and clears the fast-method bit. A hard reset does the same asynchronously.

Top module: `suspend_seq`

## Requirements
- R1: While the active-low hard reset is low, and on the first cycle after it is released, regRdData is zero, all inhibit bits are low, and flushReq and suspended are low. Asserting hard reset mid-sequence returns the block to this state without waiting for a clock edge.
- R2: Every register write loads bit 15 of regWrData into the fast-method bit, which reads back at bit 15 of regRdData from the next cycle. Bit 0 of regRdData reads 1 while a suspend request is in force. All other bits, including 31 to 16, read zero whatever was written.
- R3: A write with bit 0 set, accepted while no request is in force, latches bit 15 of that same write as the entry method: 1 means fast, 0 means draining. Later writes with bit 0 set change the readback of bit 15 but not the method of the sequence in progress.
- R4: In the fast method, from the cycle after the request write, inhibitDma and inhibitFrame are both 2'b11 and flushReq is low. Bit 0 of each is transmit and bit 1 is receive.
- R5: In the fast method, suspended rises on the cycle after the first clock edge at which all bits of dmaBusy and frameBusy are low, whatever the values of fifoEmpty and bufEmpty.
- R6: In the draining method, until suspend is reached, flushReq is high, inhibitDma is 2'b01 (new transmit DMA blocked, receive DMA allowed) and inhibitFrame is 2'b10 (new reception blocked, transmission allowed).
- R7: In the draining method, suspended rises on the cycle after the first clock edge at which all busy bits are low and all bits of fifoEmpty and bufEmpty are high. While suspended, all four inhibits are high and flushReq is low.
- R8: A write with bit 0 clear returns the block to idle on the next cycle: all inhibits, flushReq and suspended are low and bit 0 of regRdData is zero.
- R9: softRst or stopCmd high at a clock edge clears the fast-method bit and aborts any sequence to idle on the next cycle. This takes priority over a register write at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Synchronous soft reset |
| stopCmd | input | 1 | Stop command, synchronous |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 32 | Write data: bit 0 suspend request, bit 15 fast method |
| regRdData | output | 32 | Readback: bit 0 request in force, bit 15 fast method |
| dmaBusy | input | 2 | DMA transfer in progress, [0] transmit, [1] receive |
| frameBusy | input | 2 | Frame on the wire, [0] transmit, [1] receive |
| fifoEmpty | input | 2 | FIFO holds no frame, [0] transmit, [1] receive |
| bufEmpty | input | 2 | External buffer holds no frame, [0] transmit, [1] receive |
| inhibitDma | output | 2 | Block new DMA, [0] transmit, [1] receive |
| inhibitFrame | output | 2 | Block new frame, [0] transmit, [1] receive |
| flushReq | output | 1 | Drain buffered frames |
| suspended | output | 1 | Controller is suspended |

## Verification
Some properties are checked by assertions on every cycle. Suspend is entered only after a quiet edge, and in the draining method only after a drained edge. The latched method holds steady through a sequence. A release write, a stop or a soft reset leaves the block idle. The inhibit pattern matches the phase. Only the bench's scenarios can show the rest. They show that the method comes from the same write as the request, and that suspend arrives on the first qualifying cycle and no later. They also show that a fast sequence ignores non-empty buffers, that reserved bits read zero, and that an asynchronous hard reset mid-drain clears everything at once.

// File: rtl/suspend_seq_pkg.sv
package suspend_seq_pkg;

  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;
  localparam int NUM_DIR = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_SUSP = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadFast;
    logic clrFast;
    logic latchMode;
  } dp_strobe_t;

endpackage

// File: rtl/suspend_seq_ctrl.sv
module suspend_seq_ctrl
  import suspend_seq_pkg::*;
(
  input  logic       clk,
  input  logic       hardRstN,
  input  logic       softRst,
  input  logic       stopCmd,
  input  logic       regWrEn,
  input  logic       spndBit,
  input  logic       quiet,
  input  logic       drained,
  input  logic       modeFast,
  output phase_t     phase,
  output dp_strobe_t strobe
);

  phase_t phaseNext;
  logic   abortReq;
  logic   releaseReq;
  logic   enterReq;
  logic   doneNow;

  assign abortReq   = softRst | stopCmd;
  assign releaseReq = regWrEn & ~spndBit;
  assign enterReq   = regWrEn & spndBit;
  assign doneNow    = quiet & (modeFast | drained);

  always_comb begin
    phaseNext = phase;
    if (abortReq) begin
      phaseNext = PH_IDLE;
    end else if (releaseReq) begin
      phaseNext = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (enterReq) phaseNext = PH_WAIT;
        PH_WAIT: if (doneNow)  phaseNext = PH_SUSP;
        PH_SUSP: phaseNext = PH_SUSP;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) phase <= PH_IDLE;
    else           phase <= phaseNext;
  end

  always_comb begin
    strobe.clrFast   = abortReq;
    strobe.loadFast  = regWrEn & ~abortReq;
    strobe.latchMode = (phase == PH_IDLE) & enterReq & ~abortReq;
  end

  // R5: suspend is only entered after an edge where all busy inputs were low
  assert_enter_quiet_R5: assert property (@(posedge clk) disable iff (!hardRstN)
    (phase == PH_SUSP && $past(phase) != PH_SUSP) |-> $past(quiet));

  // R7: a draining sequence only ends after an edge with all buffers empty
  assert_enter_drained_R7: assert property (@(posedge clk) disable iff (!hardRstN)
    (phase == PH_SUSP && $past(phase) == PH_WAIT && !modeFast) |-> $past(drained));

  // R8: a write with the request bit clear leaves suspend on the next cycle
  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!hardRstN)
    (regWrEn && !spndBit && !softRst && !stopCmd) |=> (phase == PH_IDLE));

endmodule

// File: rtl/suspend_seq_dp.sv
module suspend_seq_dp
  import suspend_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SPND_POS = 0,
  parameter int FAST_POS = 15
) (
  input  logic                clk,
  input  logic                hardRstN,
  input  dp_strobe_t          strobe,
  input  phase_t              phase,
  input  logic                fastBitIn,
  input  logic [NUM_DIR-1:0]  dmaBusy,
  input  logic [NUM_DIR-1:0]  frameBusy,
  input  logic [NUM_DIR-1:0]  fifoEmpty,
  input  logic [NUM_DIR-1:0]  bufEmpty,
  output logic                quiet,
  output logic                drained,
  output logic                modeFast,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_DIR-1:0]  inhibitDma,
  output logic [NUM_DIR-1:0]  inhibitFrame,
  output logic                flushReq,
  output logic                suspended
);

  logic fastEn;
  logic active;
  logic draining;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)            fastEn <= 1'b0;
    else if (strobe.clrFast)  fastEn <= 1'b0;
    else if (strobe.loadFast) fastEn <= fastBitIn;
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)             modeFast <= 1'b0;
    else if (strobe.latchMode) modeFast <= fastBitIn;
  end

  assign quiet    = ~(|dmaBusy) & ~(|frameBusy);
  assign drained  = (&fifoEmpty) & (&bufEmpty);
  assign active   = (phase != PH_IDLE);
  assign draining = (phase == PH_WAIT) & ~modeFast;

  genvar d;
  generate
    for (d = 0; d < NUM_DIR; d++) begin : g_dir
      if (d == DIR_TX) begin : g_tx
        assign inhibitDma[d]   = active;
        assign inhibitFrame[d] = active & ~draining;
      end else begin : g_rx
        assign inhibitDma[d]   = active & ~draining;
        assign inhibitFrame[d] = active;
      end
    end
  endgenerate

  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_rd
      if (b == FAST_POS) begin : g_fast
        assign regRdData[b] = fastEn;
      end else if (b == SPND_POS) begin : g_spnd
        assign regRdData[b] = active;
      end else begin : g_res
        assign regRdData[b] = 1'b0;
      end
    end
  endgenerate

  assign flushReq  = draining;
  assign suspended = (phase == PH_SUSP);

  // R3: the latched method never changes during a sequence
  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!hardRstN)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(modeFast));

endmodule

// File: rtl/suspend_seq.sv
module suspend_seq
  import suspend_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SPND_POS = 0,
  parameter int FAST_POS = 15
) (
  input  logic                       clk,
  input  logic                       hardRstN,
  input  logic                       softRst,
  input  logic                       stopCmd,
  input  logic                       regWrEn,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic [NUM_DIR-1:0]         dmaBusy,
  input  logic [NUM_DIR-1:0]         frameBusy,
  input  logic [NUM_DIR-1:0]         fifoEmpty,
  input  logic [NUM_DIR-1:0]         bufEmpty,
  output logic [NUM_DIR-1:0]         inhibitDma,
  output logic [NUM_DIR-1:0]         inhibitFrame,
  output logic                       flushReq,
  output logic                       suspended
);

  phase_t     phase;
  dp_strobe_t strobe;
  logic       quiet;
  logic       drained;
  logic       modeFast;
  logic       unusedWrBits;

  assign unusedWrBits = ^regWrData;

  suspend_seq_ctrl u_ctrl (
    .clk      (clk),
    .hardRstN (hardRstN),
    .softRst  (softRst),
    .stopCmd  (stopCmd),
    .regWrEn  (regWrEn),
    .spndBit  (regWrData[SPND_POS]),
    .quiet    (quiet),
    .drained  (drained),
    .modeFast (modeFast),
    .phase    (phase),
    .strobe   (strobe)
  );

  suspend_seq_dp #(
    .DATA_W   (DATA_W),
    .SPND_POS (SPND_POS),
    .FAST_POS (FAST_POS)
  ) u_dp (
    .clk          (clk),
    .hardRstN     (hardRstN),
    .strobe       (strobe),
    .phase        (phase),
    .fastBitIn    (regWrData[FAST_POS]),
    .dmaBusy      (dmaBusy),
    .frameBusy    (frameBusy),
    .fifoEmpty    (fifoEmpty),
    .bufEmpty     (bufEmpty),
    .quiet        (quiet),
    .drained      (drained),
    .modeFast     (modeFast),
    .regRdData    (regRdData),
    .inhibitDma   (inhibitDma),
    .inhibitFrame (inhibitFrame),
    .flushReq     (flushReq),
    .suspended    (suspended)
  );

  // R7: once suspended every new activity is blocked and no flush is asked
  assert_susp_blocks_R7: assert property (@(posedge clk) disable iff (!hardRstN)
    suspended |-> (&inhibitDma && &inhibitFrame && !flushReq));

  // R6: during a drain only the emptying paths stay open
  assert_drain_lanes_R6: assert property (@(posedge clk) disable iff (!hardRstN)
    flushReq |-> (inhibitDma[DIR_TX] && inhibitFrame[DIR_RX] &&
                  !inhibitDma[DIR_RX] && !inhibitFrame[DIR_TX] && !suspended));

  // R9: stop or soft reset clears the method bit and every output
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!hardRstN)
    (softRst || stopCmd) |=> (regRdData == '0 && !suspended && !flushReq &&
                              inhibitDma == '0 && inhibitFrame == '0));

endmodule

// File: tb/tb_suspend_seq.sv
module tb_suspend_seq;

  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        softRst = 1'b0;
  logic        stopCmd = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  dmaBusy = '0;
  logic [1:0]  frameBusy = '0;
  logic [1:0]  fifoEmpty = 2'b11;
  logic [1:0]  bufEmpty = 2'b11;
  logic [1:0]  inhibitDma;
  logic [1:0]  inhibitFrame;
  logic        flushReq;
  logic        suspended;

  int    testsRun = 0;
  int    testsFailed = 0;
  string curReq = "R1";
  bit    finished = 0;

  // reference model state: 0 idle, 1 waiting, 2 suspended
  int mSt = 0;
  bit mFast = 0;
  bit mMode = 0;

  always #10 clk = ~clk;

  suspend_seq dut (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .stopCmd(stopCmd),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .dmaBusy(dmaBusy), .frameBusy(frameBusy), .fifoEmpty(fifoEmpty),
    .bufEmpty(bufEmpty), .inhibitDma(inhibitDma), .inhibitFrame(inhibitFrame),
    .flushReq(flushReq), .suspended(suspended)
  );

  always @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      mSt = 0; mFast = 0; mMode = 0;
    end else if (softRst || stopCmd) begin
      mSt = 0; mFast = 0;
    end else begin
      bit isQuiet;
      bit isDrained;
      isQuiet   = (dmaBusy == 2'b00) && (frameBusy == 2'b00);
      isDrained = (fifoEmpty == 2'b11) && (bufEmpty == 2'b11);
      if (regWrEn && !regWrData[0]) mSt = 0;
      else if (mSt == 0 && regWrEn && regWrData[0]) begin
        mSt = 1; mMode = regWrData[15];
      end else if (mSt == 1 && isQuiet && (mMode || isDrained)) mSt = 2;
      if (regWrEn) mFast = regWrData[15];
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit act;
      bit drn;
      act = (mSt != 0);
      drn = (mSt == 1) && !mMode;
      chk("regRdData", regRdData, {16'h0, mFast, 14'h0, act});
      chk("inhibitDma", {30'h0, inhibitDma}, {30'h0, act && !drn, act});
      chk("inhibitFrame", {30'h0, inhibitFrame}, {30'h0, act, act && !drn});
      chk("flushReq", {31'h0, flushReq}, {31'h0, drn});
      chk("suspended", {31'h0, suspended}, {31'h0, mSt == 2});
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      regWrEn = 1'b0;
      softRst = 1'b0;
      stopCmd = 1'b0;
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(posedge clk);
    #2;
    softRst = 1'b0;
    stopCmd = 1'b0;
    regWrEn = 1'b1;
    regWrData = d;
    step(1);
  endtask

  task automatic expectSusp(bit exp);
    @(negedge clk);
    #1;
    chk("directed suspended", {31'h0, suspended}, {31'h0, exp});
  endtask

  initial begin
    curReq = "R1";
    #45;
    hardRstN = 1'b1;
    step(3);

    curReq = "R2";
    wr(32'h0000_8000);
    step(2);
    wr(32'hFFFF_0000);
    step(1);
    wr(32'hFFFF_FFFE);
    step(2);

    // fast sequence with busy work and full buffers
    curReq = "R4";
    dmaBusy = 2'b01; frameBusy = 2'b10; fifoEmpty = 2'b00; bufEmpty = 2'b01;
    wr(32'h0000_8001);
    step(3);
    curReq = "R3";
    wr(32'h0000_0001);
    step(2);
    curReq = "R5";
    dmaBusy = 2'b00;
    step(3);
    frameBusy = 2'b00;
    step(1);
    expectSusp(1'b1);
    step(3);

    curReq = "R8";
    wr(32'h0000_0000);
    step(3);

    // draining sequence
    curReq = "R6";
    dmaBusy = 2'b10; frameBusy = 2'b10;
    wr(32'h0000_0001);
    step(3);
    dmaBusy = 2'b00; frameBusy = 2'b00;
    step(3);
    curReq = "R3";
    wr(32'h0000_8001);
    step(2);
    curReq = "R7";
    fifoEmpty = 2'b11;
    step(3);
    expectSusp(1'b0);
    bufEmpty = 2'b11;
    step(1);
    expectSusp(1'b1);
    step(3);
    wr(32'h0000_0000);
    step(2);

    // aborts
    curReq = "R9";
    fifoEmpty = 2'b01;
    wr(32'h0000_0001);
    step(3);
    @(posedge clk);
    #2;
    stopCmd = 1'b1; regWrEn = 1'b1; regWrData = 32'h0000_8001;
    step(3);
    dmaBusy = 2'b01;
    wr(32'h0000_8001);
    step(2);
    @(posedge clk);
    #2;
    softRst = 1'b1;
    step(3);

    // asynchronous hard reset mid-drain
    curReq = "R1";
    wr(32'h0000_8000);
    wr(32'h0000_0001);
    step(2);
    @(posedge clk);
    #7;
    hardRstN = 1'b0;
    #20;
    hardRstN = 1'b1;
    step(4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #4000000;
    finished = 1;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule